// File: doc/BRIEF.md
# Exception Register Bank

This block keeps the small set of registers a processor needs to enter and leave an exception handler. It holds a status word with an interrupt mask and a three-level stack of (mode, enable) pairs. It also holds a cause word with latched interrupt-pending bits and a four-bit reason code, a return address, and a faulting-address register. When the pipeline raises an exception, or when an enabled and unmasked interrupt is pending, the bank records the event in one clock edge. It pushes the mode stack, saves the address of the offending instruction and the reason code, and presents the fixed handler entry address.

The handler reads and updates the registers through a simple word-addressed read/write port. At the end it issues a return strobe, which pops the mode stack. Interrupt lines are sampled every cycle. A pending bit stays set while interrupts are disabled, so no request is lost.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset every register reads 0, `kernel_mode` is 1 and `irq_take` is 0.
- R2: `handler_pc` always equals 0x8000_0080.
- R3: On entry (exception request or taken interrupt), status bits 5:0 become the old bits 3:0 followed by two zeros. Status bits 15:8 are unchanged.
- R4: A high `hw_irq[i]` at a clock edge sets cause bit 10+i, whether or not interrupts are enabled. Set bits hold until a return strobe that is not overridden by an entry. At that point a bit clears unless its line is high in the same cycle. Cause bit 15 reads 0.
- R5: `irq_take` is 1 exactly when status bit 0 is 1, some pending bit 10+i has status bit 10+i set, and `exc_req` is 0. A taken interrupt records reason code 0.
- R6: On entry the return-address register receives `cur_pc` minus 4.
- R7: On an exception request, cause bits 5:2 receive `exc_code`. Encodings: 0 interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 system call, 9 breakpoint, 10 reserved opcode, 12 overflow. A request beats a pending interrupt in the same cycle.
- R8: The fault-address register loads `exc_vaddr` only on a request with code 4 or 5. Otherwise it holds.
- R9: A return strobe without entry makes status bits 3:0 equal the old bits 5:2 and keeps bits 5:4. When entry happens in the same cycle, the entry wins and the return is ignored.
- R10: Software address map:
  - 0 is status. Bits 15:8 and 5:0 are writable; the others read 0.
  - 1 is cause. Only bits 5:2 are writable; writes to the pending bits are ignored.
  - 2 is the return address, readable and writable.
  - 3 is the fault address, read only.
  - `sw_rdata` shows the addressed register combinationally.
  - An entry in the same cycle overrides a software write. A return strobe also overrides a status write.
- R11: `kernel_mode` is 1 exactly when status bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 4 | Reason code of the request |
| exc_vaddr | input | 32 | Data or fetch address of a faulting access |
| hw_irq | input | 5 | External interrupt lines |
| cur_pc | input | 32 | Program counter already advanced past the current instruction |
| trap_return | input | 1 | Return-from-handler strobe |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | 2 | Software register select |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected register contents |
| handler_pc | output | 32 | Handler entry address |
| irq_take | output | 1 | Interrupt is being taken this cycle |
| kernel_mode | output | 1 | Processor is in kernel mode |

## Verification
The bound checker checks the following on every cycle:
- the stack push and pop of the status mode bits;
- that the return address is the advanced PC minus four;
- that the reason code lands on a request;
- that a pending bit is sticky;
- that an interrupt is only taken with the enable bit set;
- that the fault address is stable for codes other than the two address errors.

The bench's scenarios show the interplay that no single-cycle property covers:
- an interrupt held pending while disabled and then taken once software sets the enable bit;
- the clearing of pending bits on return;
- the arbitration between entry, return and software writes in one cycle;
- the read-only nature of the pending field and the fault register.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN       = 32;
  localparam int STK_W      = 6;
  localparam int CODE_W     = 4;
  localparam int PEND_LSB   = 10;
  localparam logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0080;
  localparam logic [15:0]     STAT_WMASK   = 16'hFF3F;
  localparam logic [CODE_W-1:0] CODE_IRQ   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_ADEL  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_ADES  = 4'd5;

  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_RET   = 2'd2,
    SEL_FAULT = 2'd3
  } reg_sel_e;

  function automatic logic [STK_W-1:0] stk_push(input logic [STK_W-1:0] s);
    return {s[STK_W-3:0], 2'b00};
  endfunction

  function automatic logic [STK_W-1:0] stk_pop(input logic [STK_W-1:0] s);
    return {s[STK_W-1:STK_W-2], s[STK_W-1:2]};
  endfunction

  function automatic logic [XLEN-1:0] prior_pc(input logic [XLEN-1:0] pc);
    return pc - XLEN'(4);
  endfunction

  function automatic logic code_has_va(input logic [CODE_W-1:0] c);
    return (c == CODE_ADEL) || (c == CODE_ADES);
  endfunction
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        entry,
  input  logic        ret,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] stat
);
  logic [15:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (entry) begin
      stat_q[STK_W-1:0] <= stk_push(stat_q[STK_W-1:0]);
    end else if (ret) begin
      stat_q[STK_W-1:0] <= stk_pop(stat_q[STK_W-1:0]);
    end else if (wr_en) begin
      stat_q <= wdata & STAT_WMASK;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
#(
  parameter int N_HW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry,
  input  logic [CODE_W-1:0] code_in,
  input  logic              pend_clr,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [N_HW-1:0]   pend,
  output logic [CODE_W-1:0] code
);
  logic [N_HW-1:0]   pend_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      code_q <= '0;
    end else begin
      pend_q <= (pend_clr ? '0 : pend_q) | hw_irq;
      if (entry)      code_q <= code_in;
      else if (wr_en) code_q <= wr_code;
    end
  end

  assign pend = pend_q;
  assign code = code_q;
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            va_capture,
  input  logic [XLEN-1:0] vaddr,
  input  logic            wr_ret,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ret_pc,
  output logic [XLEN-1:0] fault_va
);
  logic [XLEN-1:0] ret_q, fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_q   <= '0;
      fault_q <= '0;
    end else begin
      if (entry)       ret_q <= prior_pc(cur_pc);
      else if (wr_ret) ret_q <= wdata;
      if (va_capture)  fault_q <= vaddr;
    end
  end

  assign ret_pc   = ret_q;
  assign fault_va = fault_q;
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int N_HW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [XLEN-1:0]     exc_vaddr,
  input  logic [N_HW-1:0]     hw_irq,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic                trap_return,
  input  logic                sw_we,
  input  logic [1:0]          sw_addr,
  input  logic [XLEN-1:0]     sw_wdata,
  output logic [XLEN-1:0]     sw_rdata,
  output logic [XLEN-1:0]     handler_pc,
  output logic                irq_take,
  output logic                kernel_mode
);
  localparam int PEND_MSB = PEND_LSB + N_HW - 1;

  logic [15:0]       stat_q;
  logic [N_HW-1:0]   pend_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   ret_q, fault_q;
  logic [N_HW-1:0]   live_irq;
  logic              trap_entry, ret_eff, va_capture;
  logic [CODE_W-1:0] entry_code;
  logic              wr_stat, wr_cause, wr_ret;
  reg_sel_e          sel;

  assign sel        = reg_sel_e'(sw_addr);
  assign live_irq   = pend_q & stat_q[PEND_MSB:PEND_LSB];
  assign irq_take   = stat_q[0] & (|live_irq) & ~exc_req;
  assign trap_entry = exc_req | irq_take;
  assign ret_eff    = trap_return & ~trap_entry;
  assign entry_code = exc_req ? exc_code : CODE_IRQ;
  assign va_capture = exc_req & code_has_va(exc_code);
  assign wr_stat    = sw_we && (sel == SEL_STAT);
  assign wr_cause   = sw_we && (sel == SEL_CAUSE);
  assign wr_ret     = sw_we && (sel == SEL_RET);

  exc_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .entry(trap_entry), .ret(trap_return),
    .wr_en(wr_stat), .wdata(sw_wdata[15:0]), .stat(stat_q)
  );

  exc_cause_reg #(.N_HW(N_HW)) u_cause (
    .clk(clk), .rst_n(rst_n), .entry(trap_entry), .code_in(entry_code),
    .pend_clr(ret_eff), .hw_irq(hw_irq), .wr_en(wr_cause),
    .wr_code(sw_wdata[CODE_W+1:2]), .pend(pend_q), .code(code_q)
  );

  exc_addr_regs u_addr (
    .clk(clk), .rst_n(rst_n), .entry(trap_entry), .cur_pc(cur_pc),
    .va_capture(va_capture), .vaddr(exc_vaddr), .wr_ret(wr_ret),
    .wdata(sw_wdata), .ret_pc(ret_q), .fault_va(fault_q)
  );

  always_comb begin
    sw_rdata = '0;
    unique case (sel)
      SEL_STAT:  sw_rdata[15:0] = stat_q;
      SEL_CAUSE: begin
        sw_rdata[PEND_MSB:PEND_LSB] = pend_q;
        sw_rdata[CODE_W+1:2]        = code_q;
      end
      SEL_RET:   sw_rdata = ret_q;
      SEL_FAULT: sw_rdata = fault_q;
      default:   sw_rdata = '0;
    endcase
  end

  assign handler_pc  = HANDLER_ADDR;
  assign kernel_mode = ~stat_q[1];
endmodule

// File: rtl/exc_regs_chk.sv
module exc_regs_chk
  import exc_pkg::*;
#(
  parameter int N_HW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              entry,
  input logic              take,
  input logic              exc_req,
  input logic [CODE_W-1:0] exc_code,
  input logic [N_HW-1:0]   hw_irq,
  input logic [XLEN-1:0]   cur_pc,
  input logic              trap_return,
  input logic [15:0]       stat,
  input logic [N_HW-1:0]   pend,
  input logic [CODE_W-1:0] code,
  input logic [XLEN-1:0]   ret_pc,
  input logic [XLEN-1:0]   fault_va
);
  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (stat[1:0] == 2'b00)); // R3
  AST_ENTRY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (stat[5:2] == $past(stat[3:0])) && (stat[15:8] == $past(stat[15:8]))); // R3
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (ret_pc + 32'd4 == $past(cur_pc))); // R6
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_irq) |=> ((pend & $past(hw_irq)) == $past(hw_irq))); // R4
  AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (stat[0] && !exc_req)); // R5
  AST_REQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (code == $past(exc_code))); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req && (exc_code == 4'd4 || exc_code == 4'd5)) |=> $stable(fault_va)); // R8
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_return && !entry) |=> (stat[3:0] == $past(stat[5:2])) && (stat[5:4] == $past(stat[5:4]))); // R9
endmodule

bind exc_ctrl_regs exc_regs_chk #(.N_HW(N_HW)) chk_i (
  .clk(clk), .rst_n(rst_n), .entry(trap_entry), .take(irq_take),
  .exc_req(exc_req), .exc_code(exc_code), .hw_irq(hw_irq), .cur_pc(cur_pc),
  .trap_return(trap_return), .stat(stat_q), .pend(pend_q), .code(code_q),
  .ret_pc(ret_q), .fault_va(fault_q)
);

// File: tb/exc_ctrl_regs_tb_top.sv
module exc_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] exc_vaddr = '0;
  logic [4:0]  hw_irq = '0;
  logic [31:0] cur_pc = '0;
  logic        trap_return = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata, handler_pc;
  logic        irq_take, kernel_mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_stat = '0;
  logic [4:0]  m_pend = '0;
  logic [3:0]  m_code = '0;
  logic [31:0] m_ret = '0, m_fault = '0;

  // stimulus for the next step
  logic        v_req = 0, v_rfe = 0, v_we = 0;
  logic [3:0]  v_code = 0;
  logic [31:0] v_va = 0, v_pc = 0, v_wd = 0;
  logic [4:0]  v_irq = 0;
  logic [1:0]  v_addr = 0;

  always #10 clk = ~clk;

  exc_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .exc_vaddr(exc_vaddr), .hw_irq(hw_irq), .cur_pc(cur_pc),
    .trap_return(trap_return), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .handler_pc(handler_pc),
    .irq_take(irq_take), .kernel_mode(kernel_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {16'h0, m_stat};
      2'd1: return {16'h0, 1'b0, m_pend, 4'h0, m_code, 2'b00};
      2'd2: return m_ret;
      default: return m_fault;
    endcase
  endfunction

  function automatic logic model_take();
    return m_stat[0] && ((m_pend & m_stat[14:10]) != 5'd0) && !v_req;
  endfunction

  task automatic idle();
    v_req = 0; v_rfe = 0; v_we = 0; v_code = 0; v_va = 0; v_irq = 0; v_wd = 0;
  endtask

  task automatic step(output logic [31:0] rd);
    logic tk, ent;
    @(negedge clk);
    exc_req = v_req; exc_code = v_code; exc_vaddr = v_va; hw_irq = v_irq;
    cur_pc = v_pc; trap_return = v_rfe; sw_we = v_we; sw_addr = v_addr; sw_wdata = v_wd;
    #2;
    tk = model_take();
    rd = sw_rdata;
    check("R5 irq_take", {31'b0, irq_take}, {31'b0, tk});
    check("R11 kernel_mode", {31'b0, kernel_mode}, {31'b0, !m_stat[1]});
    check("R2 handler_pc", handler_pc, 32'h8000_0080);
    check("R10 sw_rdata", sw_rdata, model_read(v_addr));
    @(posedge clk);
    ent = v_req | tk;
    if (ent) begin
      m_stat = (m_stat & 16'hFF00) | {10'b0, m_stat[3:0], 2'b00};
      m_code = v_req ? v_code : 4'd0;
      m_ret  = v_pc + 32'hFFFF_FFFC;
      if (v_req && (v_code == 4'd4 || v_code == 4'd5)) m_fault = v_va;
    end else begin
      if (v_rfe) m_stat = {m_stat[15:6], m_stat[5:4], m_stat[5:2]};
      else if (v_we && v_addr == 2'd0) m_stat = v_wd[15:0] & 16'hFF3F;
      if (v_we && v_addr == 2'd1) m_code = v_wd[5:2];
      if (v_we && v_addr == 2'd2) m_ret = v_wd;
    end
    m_pend = ((v_rfe && !ent) ? 5'd0 : m_pend) | v_irq;
    idle();
  endtask

  task automatic peek(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] rd;
    v_addr = a;
    step(rd);
    check(req, rd, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] rd;
    v_we = 1; v_addr = a; v_wd = d;
    step(rd);
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) peek("R1 reset", 2'(a), 32'h0);
    // R4 pending while disabled, R10 pending write ignored
    wr(2'd0, 32'h0000_7C00);
    v_irq = 5'b00100; step(rd);
    peek("R4 pend while disabled", 2'd1, 32'h0000_1000);
    wr(2'd1, 32'h0000_FC3C);
    peek("R10 pend write ignored", 2'd1, 32'h0000_103C);
    // enable -> interrupt taken next cycle, R5 code 0
    wr(2'd0, 32'h0000_7C01);
    v_pc = 32'h0000_1000; step(rd);
    peek("R3 push on irq", 2'd0, 32'h0000_7C04);
    peek("R5 code zero on irq", 2'd1, 32'h0000_1000);
    peek("R6 ret addr", 2'd2, 32'h0000_0FFC);
    // R9 return pops, R4 clear
    v_rfe = 1; step(rd);
    peek("R9 pop", 2'd0, 32'h0000_7C01);
    peek("R4 cleared on return", 2'd1, 32'h0000_0000);
    // R7 / R8 exceptions
    v_req = 1; v_code = 4'd4; v_va = 32'hDEAD_0000; v_pc = 32'h2000; step(rd);
    peek("R8 fault captured", 2'd3, 32'hDEAD_0000);
    peek("R7 code 4", 2'd1, 32'h0000_0010);
    v_req = 1; v_code = 4'd8; v_va = 32'h0000_1234; step(rd);
    peek("R8 fault held", 2'd3, 32'hDEAD_0000);
    peek("R3 second push", 2'd0, 32'h0000_7C10);
    wr(2'd3, 32'h5555_5555);
    peek("R10 fault read only", 2'd3, 32'hDEAD_0000);
    // R9 entry beats return, R10 entry beats write
    v_req = 1; v_code = 4'd12; v_rfe = 1; v_we = 1; v_addr = 2'd2; v_wd = 32'h0BAD_0BAD;
    v_pc = 32'h0000_3004; step(rd);
    peek("R9 entry beats return", 2'd0, 32'h0000_7C00);
    peek("R10 entry beats write", 2'd2, 32'h0000_3000);
    peek("R7 code 12", 2'd1, 32'h0000_0030);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      v_req  = ($urandom % 10) == 0;
      v_code = 4'($urandom % 13);
      v_va   = $urandom;
      v_pc   = $urandom;
      v_irq  = (($urandom % 6) == 0) ? 5'($urandom) : 5'd0;
      v_rfe  = ($urandom % 8) == 0;
      v_we   = ($urandom % 5) == 0;
      v_addr = 2'($urandom);
      v_wd   = $urandom;
      step(rd);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule